// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Interrupt

This peripheral keeps a 32-bit count of elapsed seconds. A prescaler divides the system clock by `CLK_HZ` to make the one-second tick. Software reaches the block through a zero-wait APB-style slave port with 32-bit data and per-byte write strobes. It can preload the count, pause it, and program a compare value.

When the count moves onto the compare value, a raw pending flag is set. This happens whether or not the interrupt is enabled. A separate enable bit passes the flag to the interrupt line and to a gated status word. A write to the acknowledge location removes the flag. A small window of constant identification words sits at the top of the 4 KB space.

The register map, by byte offset: 0x00 current seconds (read), 0x04 compare, 0x08 preload, 0x0C run control, 0x10 interrupt enable, 0x14 raw pending, 0x18 gated pending, 0x1C acknowledge. Identification words are at 0xFE0 to 0xFFC.

Top module: `rtc_secs`

## Requirements
- R1: After reset the seconds value reads 0, compare reads 0, run control reads 1, the enable reads 0, both pending words read 0 and `irq` is low.
- R2: The eight words at 0xFE0, 0xFE4, ... 0xFFC read 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that address order, with the upper 24 bits zero.
- R3: A write to the preload location (0x08) sets the seconds value to the written word and restarts the prescaler phase. While running, the value then grows by exactly one every `CLK_HZ` clock cycles, the first step coming `CLK_HZ` edges after the write edge.
- R4: Bit 0 of run control (0x0C) is the run enable. While it is 0 the seconds value holds.
- R5: Bit 0 of raw pending (0x14) becomes 1 on the edge where the seconds value changes to equal the compare value (0x04), by tick or by preload, whatever the enable bit holds. Rewriting the compare value to equal an unchanged seconds value does not set it.
- R6: Bit 0 of gated pending (0x18) is raw pending AND enable (bit 0 of 0x10). `irq` equals that gated value, so it rises on the cycle after the enable is written to 1 while raw pending is already 1.
- R7: A write of any data to the acknowledge location (0x1C) clears raw pending, gated pending and `irq`.
- R8: Byte, halfword and word writes to 0x14, 0x18 and the identification words leave their read values unchanged.
- R9: Unused addresses read as zero, and writes to them have no effect.
- R10: Writes to compare and preload update only the byte lanes whose `pstrb` bit is 1. Reads always return the full 32-bit word, from which the master takes its lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the prescaler source |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Word address (byte address bits 11:2) |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte-lane write strobes |
| prdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Gated interrupt request |

## Verification
On every cycle, the bound checker confirms several things. The seconds value moves only by a single step or by a preload. It holds while the run enable is low. Raw pending sets whenever the value lands on the compare value, and never rises without a change in the seconds value. An acknowledge with no coincident change leaves the line low. The bench scenarios are needed for the rest: the exact tick period and the prescaler restart, the identification bytes, the enable gating of `irq`, the no-refire rule on a compare rewrite, and the immunity of read-only and unused locations to writes of every size.

// File: rtl/rtc_secs.sv
module rtc_secs #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [9:0]  paddr,
  input  logic [31:0] pwdata,
  input  logic [3:0]  pstrb,
  output logic [31:0] prdata,
  output logic        irq
);
  localparam int DIV_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HZ - 1);

  localparam logic [9:0] A_SECS  = 10'h000;
  localparam logic [9:0] A_CMP   = 10'h001;
  localparam logic [9:0] A_PRE   = 10'h002;
  localparam logic [9:0] A_RUN   = 10'h003;
  localparam logic [9:0] A_IEN   = 10'h004;
  localparam logic [9:0] A_RAW   = 10'h005;
  localparam logic [9:0] A_GATED = 10'h006;
  localparam logic [9:0] A_ACK   = 10'h007;

  logic [31:0]      secs_q, cmp_q, pre_q;
  logic [DIV_W-1:0] div_q;
  logic             run_q, ien_q, raw_q;

  logic [31:0]      secs_nxt, pre_nxt;
  logic [DIV_W-1:0] div_nxt;
  logic             hit;

  wire wr     = psel & penable & pwrite;
  wire wr_cmp = wr & (paddr == A_CMP);
  wire wr_pre = wr & (paddr == A_PRE);
  wire wr_run = wr & (paddr == A_RUN) & pstrb[0];
  wire wr_ien = wr & (paddr == A_IEN) & pstrb[0];
  wire wr_ack = wr & (paddr == A_ACK);

  function automatic logic [31:0] lanes(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    for (int i = 0; i < 4; i++)
      lanes[8*i +: 8] = be[i] ? nw[8*i +: 8] : old[8*i +: 8];
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  assign pre_nxt = lanes(pre_q, pwdata, pstrb);

  always_comb begin
    secs_nxt = secs_q;
    div_nxt  = div_q;
    if (wr_pre) begin
      secs_nxt = pre_nxt;
      div_nxt  = '0;
    end else if (run_q) begin
      if (div_q == DIV_LAST) begin
        div_nxt  = '0;
        secs_nxt = secs_q + 32'd1;
      end else begin
        div_nxt = div_q + 1'b1;
      end
    end
  end

  assign hit = (secs_nxt != secs_q) && (secs_nxt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q <= '0;
      div_q  <= '0;
      cmp_q  <= '0;
      pre_q  <= '0;
      run_q  <= 1'b1;
      ien_q  <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      secs_q <= secs_nxt;
      div_q  <= div_nxt;
      if (wr_cmp) cmp_q <= lanes(cmp_q, pwdata, pstrb);
      if (wr_pre) pre_q <= pre_nxt;
      if (wr_run) run_q <= pwdata[0];
      if (wr_ien) ien_q <= pwdata[0];
      raw_q <= hit | (raw_q & ~wr_ack);
    end
  end

  assign irq = raw_q & ien_q;

  always_comb begin
    prdata = '0;
    if (paddr[9:3] == 7'h7F)
      prdata = {24'd0, id_byte(paddr[2:0])};
    else
      case (paddr)
        A_SECS:  prdata = secs_q;
        A_CMP:   prdata = cmp_q;
        A_PRE:   prdata = pre_q;
        A_RUN:   prdata = {31'd0, run_q};
        A_IEN:   prdata = {31'd0, ien_q};
        A_RAW:   prdata = {31'd0, raw_q};
        A_GATED: prdata = {31'd0, irq};
        default: prdata = '0;
      endcase
  end
endmodule

// File: rtl/rtc_secs_chk.sv
module rtc_secs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [9:0]  paddr,
  input logic [31:0] secs_q,
  input logic [31:0] cmp_q,
  input logic        run_q,
  input logic        raw_q,
  input logic        irq
);
  wire wr_pre = psel & penable & pwrite & (paddr == 10'h002);
  wire wr_ack = psel & penable & pwrite & (paddr == 10'h007);

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_pre) && secs_q != $past(secs_q)) |-> secs_q == $past(secs_q) + 32'd1);

  assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_q) && !$past(wr_pre)) |-> secs_q == $past(secs_q));

  assert_hit_sets_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (secs_q != $past(secs_q) && secs_q == $past(cmp_q)) |-> raw_q);

  assert_raw_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> secs_q != $past(secs_q));

  assert_ack_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_ack) && secs_q == $past(secs_q)) |-> (!raw_q && !irq));
endmodule

bind rtc_secs rtc_secs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .secs_q(secs_q), .cmp_q(cmp_q), .run_q(run_q), .raw_q(raw_q), .irq(irq)
);

// File: tb/rtc_secs_tb.sv
module rtc_secs_tb;
  localparam int HZ = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [31:0] prdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  rtc_secs #(.CLK_HZ(HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a[11:2]; pwdata = d; pstrb = be;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pstrb = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a[11:2];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    #2;
    compared++;
    if (irq !== e) begin
      mismatched++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (psel && penable && !pwrite && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (prdata !== e) begin
        mismatched++;
        $display("FAIL %s addr=%03h actual=%08h expected=%08h", t, {paddr, 2'b00}, prdata, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 20000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values (count still 0: fewer than HZ edges pass)
    rd(12'h000, 32'd0, "R1 secs");
    rd(12'h00C, 32'd1, "R1 run");
    rd(12'h004, 32'd0, "R1 cmp");
    rd(12'h010, 32'd0, "R1 ien");
    rd(12'h014, 32'd0, "R1 raw");
    rd(12'h018, 32'd0, "R1 gated");
    chk_irq(1'b0, "R1 irq");

    // R2 identification words
    for (int i = 0; i < 8; i++) begin
      logic [7:0] idv [8];
      idv = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      rd(12'hFE0 + 12'(4 * i), {24'd0, idv[i]}, "R2 id");
    end

    // R3 preload and tick period
    wr(12'h008, 32'h0000_1000, 4'hF);
    repeat (4) @(negedge clk);
    rd(12'h000, 32'h0000_1000, "R3 before first tick");
    wr(12'h008, 32'h0000_2000, 4'hF);
    repeat (24) @(negedge clk);
    rd(12'h000, 32'h0000_2002, "R3 two seconds");
    rd(12'h008, 32'h0000_2000, "R3 preload readback");

    // R4 stopped counter holds
    wr(12'h00C, 32'h0, 4'h1);
    wr(12'h008, 32'h0000_0050, 4'hF);
    repeat (30) @(negedge clk);
    rd(12'h000, 32'h0000_0050, "R4 frozen");
    rd(12'h00C, 32'h0, "R4 run bit");

    // R10 byte lanes on compare and preload
    wr(12'h004, 32'h1122_3344, 4'hF);
    wr(12'h004, 32'hAABB_CCDD, 4'b0010);
    rd(12'h004, 32'h1122_CC44, "R10 cmp lane1");
    wr(12'h008, 32'hAABB_CCDD, 4'b1100);
    rd(12'h008, 32'hAABB_0050, "R10 preload lanes");
    rd(12'h000, 32'hAABB_0050, "R10 secs from merged preload");

    // R5 tick onto compare with enable low
    wr(12'h004, 32'd7, 4'hF);
    wr(12'h00C, 32'h1, 4'h1);
    wr(12'h008, 32'd5, 4'hF);
    repeat (21) @(negedge clk);
    rd(12'h014, 32'd1, "R5 raw set while disabled");
    wr(12'h00C, 32'h0, 4'h1);
    rd(12'h000, 32'd7, "R5 count at compare");
    rd(12'h018, 32'd0, "R6 gated while disabled");
    chk_irq(1'b0, "R6 irq masked");

    // R8 read-only locations ignore writes of all sizes
    wr(12'h014, 32'hDEAD_BEEF, 4'b0001);
    wr(12'h014, 32'hDEAD_BEEF, 4'b0011);
    wr(12'h014, 32'hDEAD_BEEF, 4'b1111);
    rd(12'h014, 32'd1, "R8 raw unchanged");
    wr(12'h018, 32'hDEAD_BEEF, 4'b1111);
    rd(12'h018, 32'd0, "R8 gated unchanged");
    wr(12'hFE0, 32'hDEAD_BEEF, 4'b0001);
    wr(12'hFE8, 32'hDEAD_BEEF, 4'b0011);
    wr(12'hFFC, 32'hDEAD_BEEF, 4'b1111);
    rd(12'hFE0, 32'h31, "R8 id0");
    rd(12'hFE8, 32'h14, "R8 id2");
    rd(12'hFFC, 32'hB1, "R8 id7");

    // R9 unused addresses
    wr(12'h020, 32'hFFFF_FFFF, 4'hF);
    wr(12'h800, 32'hFFFF_FFFF, 4'hF);
    rd(12'h020, 32'd0, "R9 unused 0x20");
    rd(12'h800, 32'd0, "R9 unused 0x800");
    rd(12'h000, 32'd7, "R9 secs untouched");

    // R6 enable with pending raw
    wr(12'h010, 32'h1, 4'h1);
    chk_irq(1'b1, "R6 irq after enable");
    rd(12'h018, 32'd1, "R6 gated set");

    // R7 acknowledge with arbitrary data
    wr(12'h01C, 32'h8000_0000, 4'hF);
    chk_irq(1'b0, "R7 irq cleared");
    rd(12'h014, 32'd0, "R7 raw cleared");
    rd(12'h018, 32'd0, "R7 gated cleared");

    // R5 compare rewrite to current value does not refire
    wr(12'h004, 32'd7, 4'hF);
    repeat (3) @(negedge clk);
    rd(12'h014, 32'd0, "R5 no refire");
    chk_irq(1'b0, "R5 no refire irq");

    // R5 preload onto compare fires
    wr(12'h004, 32'd9, 4'hF);
    wr(12'h008, 32'd9, 4'hF);
    rd(12'h014, 32'd1, "R5 preload hit");
    chk_irq(1'b1, "R5 preload hit irq");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule